// File: doc/BRIEF.md
# Carry-Save Pipelined Multiply-Accumulator

This block multiplies two signed W-bit operands on every accepted cycle and adds the product to a running total. A per-input control decides whether the product is added to the total or starts a new total. The total is kept in redundant form, as a pair of vectors whose sum is the true value. This means no carry-propagating adder sits in the accumulation loop. A separate registered adder turns the pair into a single resolved result.

The unit has three pipeline stages. The first stage registers the operands, the accumulate control and the valid flag. The second stage generates the partial products and compresses them, together with the two gated accumulator vectors, into a new sum/carry pair. The third stage resolves that pair with one carry-propagate adder. A parameter selects the partial-product scheme: radix-4 recoded rows or a plain signed array. Both schemes give the same arithmetic result.

Top module: `mac_cs_top`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `res_valid` is 0 and `res_sum` is 0.
- R2: An input accepted with `in_valid`=1 at a clock edge makes `res_valid` go high for exactly one cycle after the third edge that follows. `res_valid` is never high at any other time.
- R3: An accepted input with `acc_en`=1 adds the product `op_a*op_b` to the running total. The resolved `res_sum` equals the total including that input.
- R4: An accepted input with `acc_en`=0 discards the previous total. Its result, and the new total, equal the product alone.
- R5: A cycle with `in_valid`=0 leaves the running total unchanged and produces no result. `res_sum` holds its last value until the next result.
- R6: Operands are two's complement. The product is sign-extended to 2W+2 bits. This includes the corner cases of the most negative value times itself, times -1, and times the most positive value.
- R7: The total has 2W+2 bits and wraps modulo 2^(2W+2) with no saturation.
- R8: The recoded-row variant (`USE_BOOTH`=1) and the plain-array variant (`USE_BOOTH`=0) give bit-identical results for the same input stream.
- R9: Accepted inputs on consecutive cycles each give their own result on consecutive cycles, in input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and control are valid this cycle |
| acc_en | input | 1 | 1: add the product to the total; 0: restart the total from the product |
| op_a | input | W | Signed multiplicand |
| op_b | input | W | Signed multiplier |
| res_valid | output | 1 | `res_sum` carries the total that includes a newly accepted input |
| res_sum | output | 2W+2 | Resolved running total, two's complement |

## Verification
Every result is due three clock edges after the edge that accepts its input. The bench therefore keeps a short ring of expected entries indexed by cycle. When it drives an input at a falling edge, it files the expected valid flag and total three slots ahead. At each later falling edge, before it drives anything new, it compares both the valid flag and the total with the entry due in that slot. Idle slots expect `res_valid` low. This means a result that is early, late, missing or extra is caught in the exact cycle where it goes wrong. Both partial-product variants sit on the same input stream and are checked against the same entries.

// File: rtl/mac_pkg.sv
// Shared constants and helpers for the carry-save multiply-accumulator.
// Assumes: operand width is even when radix-4 recoding is used.
package mac_pkg;

    // Edges from input acceptance to a visible result.
    localparam int unsigned PIPE_LAT = 3;

    // Number of partial-product rows for a given width and scheme.
    function automatic int unsigned pp_rows(input int unsigned w, input bit booth);
        return booth ? (w / 2) : w;
    endfunction

endpackage

// File: rtl/mac_pp_gen.sv
// Partial-product generator.
// Produces NPP rows, each a full ACC-bit two's-complement value already
// shifted to its weight, so the rows sum (mod 2^ACC) to a*b.
// Assumes: ACC >= 2*W, and W is even when USE_BOOTH=1.
module mac_pp_gen #(
    parameter int unsigned W         = 64,
    parameter int unsigned ACC       = 2 * W + 2,
    parameter bit          USE_BOOTH = 1'b1,
    parameter int unsigned NPP       = mac_pkg::pp_rows(W, USE_BOOTH)
) (
    input  logic [W-1:0]             a,
    input  logic [W-1:0]             b,
    output logic [NPP-1:0][ACC-1:0]  pp
);

    logic [ACC-1:0] a_ext;

    // Sign-extend the multiplicand to the accumulator width.
    always_comb a_ext = {{(ACC-W){a[W-1]}}, a};

    if (USE_BOOTH) begin : g_booth
        for (genvar j = 0; j < NPP; j++) begin : g_row
            logic       lsb;
            logic [2:0] grp;
            if (j == 0) begin : g_first
                assign lsb = 1'b0;
            end else begin : g_rest
                assign lsb = b[2*j-1];
            end
            assign grp = {b[2*j+1], b[2*j], lsb};

            // Select 0, +-a or +-2a from the overlapping bit triple.
            always_comb begin
                unique case (grp)
                    3'b001, 3'b010: pp[j] = a_ext << (2 * j);
                    3'b011:         pp[j] = a_ext << (2 * j + 1);
                    3'b100:         pp[j] = -(a_ext << (2 * j + 1));
                    3'b101, 3'b110: pp[j] = -(a_ext << (2 * j));
                    default:        pp[j] = '0;
                endcase
            end
        end
    end else begin : g_array
        for (genvar i = 0; i < NPP; i++) begin : g_row
            if (i == NPP - 1) begin : g_sign
                // The top multiplier bit carries negative weight.
                always_comb pp[i] = b[i] ? -(a_ext << i) : '0;
            end else begin : g_mag
                // Ordinary rows: shifted multiplicand or zero.
                always_comb pp[i] = b[i] ? (a_ext << i) : '0;
            end
        end
    end

endmodule

// File: rtl/mac_cs_accum.sv
// Carry-save accumulator stage.
// Compresses all partial-product rows and the gated previous sum/carry pair
// through a chain of 3:2 compressors into a new pair, which is registered.
// Carries out of the top bit are dropped, which gives modulo-2^ACC wrap.
// Assumes: pp rows are already sign-extended to ACC bits.
module mac_cs_accum #(
    parameter int unsigned ACC = 130,
    parameter int unsigned NPP = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic                     en_in,
    input  logic [NPP-1:0][ACC-1:0]  pp,
    output logic [ACC-1:0]           acc_s,
    output logic [ACC-1:0]           acc_c,
    output logic                     v_out
);

    logic [ACC-1:0] nxt_s;
    logic [ACC-1:0] nxt_c;

    // Reduce rows plus gated feedback into two vectors, with no carry ripple.
    always_comb begin
        logic [ACC-1:0] s;
        logic [ACC-1:0] c;
        logic [ACC-1:0] t;
        s = acc_s & {ACC{en_in}};
        c = acc_c & {ACC{en_in}};
        for (int i = 0; i < NPP; i++) begin
            t = s ^ c ^ pp[i];
            c = ((s & c) | (s & pp[i]) | (c & pp[i])) << 1;
            s = t;
        end
        nxt_s = s;
        nxt_c = c;
    end

    // Update the redundant total only on accepted cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_s <= '0;
            acc_c <= '0;
        end else if (v_in) begin
            acc_s <= nxt_s;
            acc_c <= nxt_c;
        end
    end

    // Pass the valid flag on to the resolving stage.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

endmodule

// File: rtl/mac_cpa.sv
// Registered carry-propagate adder.
// Resolves the sum/carry pair into one value, outside the feedback loop.
// The output is held when no new total arrives.
module mac_cpa #(
    parameter int unsigned ACC = 130
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           v_in,
    input  logic [ACC-1:0] s_in,
    input  logic [ACC-1:0] c_in,
    output logic           v_out,
    output logic [ACC-1:0] sum_out
);

    // Add the two vectors and register the resolved value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_out <= '0;
            v_out   <= 1'b0;
        end else begin
            v_out <= v_in;
            if (v_in) sum_out <= s_in + c_in;
        end
    end

endmodule

// File: rtl/mac_cs_top.sv
// Signed multiply-accumulate with a carry-save running total.
// Stage 1 registers the inputs. Stage 2 generates the partial products and
// compresses them with the total. Stage 3 resolves the pair.
// Assumes: W even when USE_BOOTH=1.
module mac_cs_top #(
    parameter int unsigned W         = 64,
    parameter bit          USE_BOOTH = 1'b1,
    parameter int unsigned ACC       = 2 * W + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           acc_en,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic           res_valid,
    output logic [ACC-1:0] res_sum
);

    localparam int unsigned NPP = mac_pkg::pp_rows(W, USE_BOOTH);

    logic                    s1_valid;
    logic                    s1_en;
    logic [W-1:0]            s1_a;
    logic [W-1:0]            s1_b;
    logic [NPP-1:0][ACC-1:0] rows;
    logic [ACC-1:0]          acc_s;
    logic [ACC-1:0]          acc_c;
    logic                    s2_valid;

    // Stage 1: capture operands and control together with their valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_en    <= 1'b0;
            s1_a     <= '0;
            s1_b     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_en <= acc_en;
                s1_a  <= op_a;
                s1_b  <= op_b;
            end
        end
    end

    mac_pp_gen #(
        .W(W), .ACC(ACC), .USE_BOOTH(USE_BOOTH), .NPP(NPP)
    ) pp_i (
        .a  (s1_a),
        .b  (s1_b),
        .pp (rows)
    );

    mac_cs_accum #(
        .ACC(ACC), .NPP(NPP)
    ) acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (s1_valid),
        .en_in (s1_en),
        .pp    (rows),
        .acc_s (acc_s),
        .acc_c (acc_c),
        .v_out (s2_valid)
    );

    mac_cpa #(
        .ACC(ACC)
    ) cpa_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .v_in    (s2_valid),
        .s_in    (acc_s),
        .c_in    (acc_c),
        .v_out   (res_valid),
        .sum_out (res_sum)
    );

endmodule

// File: rtl/mac_cs_chk.sv
// Timing and hold properties of the multiply-accumulator, attached to the
// top module with a bind statement.
module mac_cs_chk #(
    parameter int unsigned ACC = 130
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           s1_valid,
    input logic [ACC-1:0] acc_s,
    input logic [ACC-1:0] acc_c,
    input logic           res_valid,
    input logic [ACC-1:0] res_sum
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!res_valid && res_sum == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(in_valid, 3));

    // R5
    idle_hold_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(acc_s) && $stable(acc_c)));

    // R5
    idle_hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_sum));

endmodule

bind mac_cs_top mac_cs_chk #(.ACC(ACC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .s1_valid  (s1_valid),
    .acc_s     (acc_s),
    .acc_c     (acc_c),
    .res_valid (res_valid),
    .res_sum   (res_sum)
);

// File: tb/mac_cs_top_tb.sv
// Directed bench: each task drives one scenario and checks its own results
// against a wide reference total, three edges after each input.
module mac_cs_top_tb_top;

    localparam int unsigned W   = 64;
    localparam int unsigned ACC = 2 * W + 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           acc_en = 1'b0;
    logic [W-1:0]   op_a = '0;
    logic [W-1:0]   op_b = '0;
    logic           res_valid, res_valid_arr;
    logic [ACC-1:0] res_sum, res_sum_arr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [ACC-1:0] ref_acc = '0;
    logic           exp_v [8];
    logic [ACC-1:0] exp_s [8];

    always #5 clk = ~clk;

    mac_cs_top #(.W(W), .USE_BOOTH(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_en(acc_en),
        .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_sum(res_sum)
    );

    mac_cs_top #(.W(W), .USE_BOOTH(1'b0)) dut_arr_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_en(acc_en),
        .op_a(op_a), .op_b(op_b), .res_valid(res_valid_arr), .res_sum(res_sum_arr)
    );

    task automatic chk(input string req, input logic [ACC-1:0] act, input logic [ACC-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One cycle: compare what is due now, then drive and file the next expectation.
    task automatic step(input logic v, input logic en, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string req);
        logic [ACC-1:0] ea, eb;
        int slot;
        @(negedge clk);
        slot = cyc % 8;
        chk({"R2 valid ", req}, ACC'(res_valid), ACC'(exp_v[slot]));
        chk({"R8 valid ", req}, ACC'(res_valid_arr), ACC'(exp_v[slot]));
        if (exp_v[slot]) begin
            chk(req, res_sum, exp_s[slot]);
            chk({"R8 ", req}, res_sum_arr, exp_s[slot]);
        end
        exp_v[slot] = 1'b0;
        in_valid = v; acc_en = en; op_a = a; op_b = b;
        if (v) begin
            ea = {{(ACC-W){a[W-1]}}, a};
            eb = {{(ACC-W){b[W-1]}}, b};
            ref_acc = (en ? ref_acc : '0) + ea * eb;
            exp_v[(cyc + 3) % 8] = 1'b1;
            exp_s[(cyc + 3) % 8] = ref_acc;
        end
        cyc++;
    endtask

    task automatic flush(input string req);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, '0, req);
    endtask

    // R1: reset state on both variants.
    task automatic t_reset();
        for (int i = 0; i < 8; i++) exp_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", ACC'(res_valid), '0);
        chk("R1 sum", res_sum, '0);
        chk("R1 valid arr", ACC'(res_valid_arr), '0);
    endtask

    // R3, R4: restart then accumulate small known values.
    task automatic t_accumulate();
        step(1'b1, 1'b0, 64'd3, 64'd5, "R4");
        step(1'b1, 1'b1, 64'd7, 64'd2, "R3");
        step(1'b1, 1'b1, -64'sd4, 64'd6, "R3");
        step(1'b1, 1'b0, 64'd9, 64'd9, "R4");
        flush("R4");
    endtask

    // R5: gaps leave the total alone and produce no result.
    task automatic t_gaps();
        step(1'b1, 1'b1, 64'd100, 64'd100, "R5");
        step(1'b0, 1'b0, 64'hFFFF, 64'hFFFF, "R5");
        step(1'b0, 1'b1, 64'd1234, 64'd77, "R5");
        step(1'b1, 1'b1, 64'd1, 64'd1, "R5");
        flush("R5");
    endtask

    // R6: signed corner operands.
    task automatic t_signed();
        logic [W-1:0] mn, mx;
        mn = {1'b1, {(W-1){1'b0}}};
        mx = {1'b0, {(W-1){1'b1}}};
        step(1'b1, 1'b0, mn, mn, "R6");
        step(1'b1, 1'b0, mn, '1, "R6");
        step(1'b1, 1'b0, mn, mx, "R6");
        step(1'b1, 1'b1, mx, mx, "R6");
        step(1'b1, 1'b0, '1, '1, "R6");
        flush("R6");
    endtask

    // R7: sixteen additions of 2^(2W-2) wrap the total back to zero.
    task automatic t_wrap();
        logic [W-1:0] mn;
        mn = {1'b1, {(W-1){1'b0}}};
        step(1'b1, 1'b0, mn, mn, "R7");
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1, mn, mn, "R7");
        step(1'b1, 1'b1, 64'd5, 64'd1, "R7");
        flush("R7");
    endtask

    // R9, R8: back-to-back random stream with random restarts.
    task automatic t_stream();
        for (int i = 0; i < 300; i++)
            step(1'b1, ($urandom % 8) != 0, {$urandom, $urandom}, {$urandom, $urandom}, "R9");
        for (int i = 0; i < 200; i++)
            step(($urandom % 3) != 0, ($urandom % 6) != 0,
                 {$urandom, $urandom}, {$urandom, $urandom}, "R9");
        flush("R9");
    endtask

    initial begin
        t_reset();
        t_accumulate();
        t_gaps();
        t_signed();
        t_wrap();
        t_stream();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule